// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is the target-side scan data register through which an external debugger reaches a small file of 32-bit debug registers. A 38-bit packet is shifted through it, least significant bit first. The packet carries a 32-bit data word, then a 5-bit register address, then a direction flag. The block runs entirely in the test clock domain. It is driven by three strobes from a TAP controller that lies outside the block: capture, shift and update.

On the update strobe the packet's address becomes the selected register. If the direction flag is 1, the data word is also written into that register. On the next capture strobe the selected register's value is loaded into the data field, ready to shift out. A read therefore takes two scans. The first scan names the register. The second scan returns its contents and can already carry the next address, so a run of reads is pipelined.

The file holds a debug control register, a read-only debug status view of the core, two communications registers, and two watch units of six registers each. It can also hold an optional vector-catch register. Control bit 4 enables monitor mode and is driven out to the core.

Top module: `dbg_scan_chain`

## Requirements
- R1: Bits enter on `tdi_i` and leave on `tdo_o` least significant bit first. Packet bit i is the i-th bit shifted in. Bits 31..0 are data, bits 36..32 are the address and bit 37 is the flag. After a capture, the first bit on `tdo_o` is data bit 0.
- R2: At an update strobe with flag 1, the data word is written into the addressed register. At an update strobe with flag 0, no register changes.
- R3: A capture strobe loads the value of the register addressed by the most recent update strobe into the data field. Read data therefore appears in the scan after the one that supplied the address.
- R4: The watch unit registers are at 0x08–0x0D (unit 0) and 0x10–0x15 (unit 1). Each unit has six independent 32-bit registers, in the order address value, address mask, data value, data mask, control value, control mask. The comms control register is at 0x04 and the comms data register at 0x05.
- R5: Debug control at 0x00 holds CTRL_W bits (default 6). Its upper bits read as zero. Its bit 4 drives `mon_en_o`, and it can be cleared by writing back a read value with bit 4 cleared.
- R6: Debug status at 0x01 reads `core_status_i` zero-extended. Writes to it are ignored.
- R7: With VC_EN=1, address 0x02 is a 32-bit vector-catch register. With VC_EN=0 it reads zero and writes to it are ignored.
- R8: Unimplemented addresses (for example 0x03 and 0x1F) read zero, and writes to them change no register.
- R9: Synchronous active-low reset clears all registers, the selection (to 0x00) and the shift register, so `tdo_o` and `dbg_ctrl_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| cap_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| upd_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (shift register bit 0) |
| core_status_i | input | STAT_W | Core status bits shown at address 0x01 |
| dbg_ctrl_o | output | CTRL_W | Debug control register contents |
| mon_en_o | output | 1 | Monitor-mode enable (control bit 4) |

## Verification
The bench builds two copies side by side from the same stimulus. One has VC_EN=1 and the other has VC_EN=0, and both keep the default widths and two watch units. With both copies present, one write to address 0x02 shows the register holding data in the first copy and reading zero in the second. The default narrow control and status widths expose the zero upper bits. The two watch units make the gap between 0x0D and 0x10 reachable.

// File: rtl/dbg_chain_pkg.sv
// Package: shared widths, address map and packet layout for the debug scan chain.
// Assumes a 5-bit address space; watch units sit at multiples of 8 starting at 8.
package dbg_chain_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 5;
    localparam int PKT_W      = DATA_W + ADDR_W + 1;
    localparam int WATCH_REGS = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h01;
    localparam logic [ADDR_W-1:0] A_VCAT = 5'h02;
    localparam logic [ADDR_W-1:0] A_CCTL = 5'h04;
    localparam logic [ADDR_W-1:0] A_CDAT = 5'h05;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } pkt_t;
endpackage

// File: rtl/dbg_shift_reg.sv
// Module: 38-bit serial packet register. Capture loads the data field only;
// shift moves bits toward bit 0 (LSB-first). Assumes strobes are mutually exclusive.
module dbg_shift_reg
    import dbg_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic              tdi_i,
    input  logic [DATA_W-1:0] cap_data_i,
    output logic              tdo_o,
    output pkt_t              pkt_o
);
    logic [PKT_W-1:0] sr;

    // Packet register: reset, capture into data field, or shift one place.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr <= '0;
        else if (cap_i)   sr[DATA_W-1:0] <= cap_data_i;
        else if (shift_i) sr <= {tdi_i, sr[PKT_W-1:1]};
    end

    assign tdo_o = sr[0];
    assign pkt_o = pkt_t'(sr);

    p_shift_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !cap_i) |=> (sr[PKT_W-2:0] == $past(sr[PKT_W-1:1]) && sr[PKT_W-1] == $past(tdi_i)));
    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !cap_i) |=> $stable(sr));
endmodule

// File: rtl/dbg_reg_file.sv
// Module: debug register file. One write port (update strobe) and one
// combinational read port (selected address). Assumes N_WATCH <= 3, CTRL_W in 5..31.
module dbg_reg_file
    import dbg_chain_pkg::*;
#(
    parameter int CTRL_W  = 6,
    parameter int STAT_W  = 5,
    parameter bit VC_EN   = 1'b1,
    parameter int N_WATCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [STAT_W-1:0] status_i,
    output logic [CTRL_W-1:0] ctrl_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] cctl_q, cdat_q, vc_rd;
    logic [N_WATCH-1:0][DATA_W-1:0] watch_rd;

    // Control and comms registers: plain write-enabled storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cctl_q <= '0;
            cdat_q <= '0;
        end else if (we_i) begin
            if (waddr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
            if (waddr_i == A_CCTL) cctl_q <= wdata_i;
            if (waddr_i == A_CDAT) cdat_q <= wdata_i;
        end
    end

    // One block of six registers per watch unit, based at 8*(unit+1).
    for (genvar u = 0; u < N_WATCH; u++) begin : g_watch
        localparam logic [1:0] UID = 2'(u + 1);
        logic [DATA_W-1:0] regs [WATCH_REGS];
        logic w_hit, r_hit;
        assign w_hit = (waddr_i[4:3] == UID) && (waddr_i[2:0] < 3'(WATCH_REGS));
        assign r_hit = (raddr_i[4:3] == UID) && (raddr_i[2:0] < 3'(WATCH_REGS));

        // Watch unit storage write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < WATCH_REGS; i++) regs[i] <= '0;
            end else if (we_i && w_hit) begin
                regs[waddr_i[2:0]] <= wdata_i;
            end
        end
        assign watch_rd[u] = r_hit ? regs[raddr_i[2:0]] : '0;
    end

    // Optional vector-catch register.
    if (VC_EN) begin : g_vc
        logic [DATA_W-1:0] vc_q;
        // Vector-catch storage write.
        always_ff @(posedge clk) begin
            if (!rst_n)                          vc_q <= '0;
            else if (we_i && waddr_i == A_VCAT) vc_q <= wdata_i;
        end
        assign vc_rd = vc_q;
    end else begin : g_no_vc
        assign vc_rd = '0;
        p_vc_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr_i == A_VCAT) |-> (rdata_o == '0));
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        rdata_o = '0;
        case (raddr_i)
            A_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
            A_STAT:  rdata_o[STAT_W-1:0] = status_i;
            A_VCAT:  rdata_o = vc_rd;
            A_CCTL:  rdata_o = cctl_q;
            A_CDAT:  rdata_o = cdat_q;
            default: for (int u = 0; u < N_WATCH; u++) rdata_o = rdata_o | watch_rd[u];
        endcase
    end

    assign ctrl_o = ctrl_q;

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && waddr_i == A_CTRL) |=> (ctrl_q == $past(wdata_i[CTRL_W-1:0])));
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && waddr_i == A_CTRL) |=> $stable(ctrl_q));
    p_ctrl_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_i == A_CTRL) |-> (rdata_o[DATA_W-1:CTRL_W] == '0));
    p_status_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_i == A_STAT) |-> (rdata_o == DATA_W'(status_i)));
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_i == 5'h03 || raddr_i == 5'h1F) |-> (rdata_o == '0));
endmodule

// File: rtl/dbg_scan_chain.sv
// Module: top of the debug register scan chain. Joins the packet register to the
// register file; update writes and selects, capture reads the selection.
// Assumes a TAP controller outside drives one strobe at a time, all on tck_i.
module dbg_scan_chain
    import dbg_chain_pkg::*;
#(
    parameter int CTRL_W  = 6,
    parameter int STAT_W  = 5,
    parameter bit VC_EN   = 1'b1,
    parameter int N_WATCH = 2
) (
    input  logic              tck_i,
    input  logic              rst_n_i,
    input  logic              cap_i,
    input  logic              shift_i,
    input  logic              upd_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic [STAT_W-1:0] core_status_i,
    output logic [CTRL_W-1:0] dbg_ctrl_o,
    output logic              mon_en_o
);
    localparam int MON_BIT = 4;

    pkt_t              pkt;
    logic [DATA_W-1:0] rdata;
    logic [ADDR_W-1:0] sel_q;
    logic              we;

    dbg_shift_reg u_sr (
        .clk        (tck_i),
        .rst_n      (rst_n_i),
        .cap_i      (cap_i),
        .shift_i    (shift_i),
        .tdi_i      (tdi_i),
        .cap_data_i (rdata),
        .tdo_o      (tdo_o),
        .pkt_o      (pkt)
    );

    assign we = upd_i && pkt.wr;

    // Read selection: latched from the packet address on every update.
    always_ff @(posedge tck_i) begin
        if (!rst_n_i)   sel_q <= '0;
        else if (upd_i) sel_q <= pkt.addr;
    end

    dbg_reg_file #(
        .CTRL_W  (CTRL_W),
        .STAT_W  (STAT_W),
        .VC_EN   (VC_EN),
        .N_WATCH (N_WATCH)
    ) u_rf (
        .clk      (tck_i),
        .rst_n    (rst_n_i),
        .we_i     (we),
        .waddr_i  (pkt.addr),
        .wdata_i  (pkt.data),
        .raddr_i  (sel_q),
        .rdata_o  (rdata),
        .status_i (core_status_i),
        .ctrl_o   (dbg_ctrl_o)
    );

    assign mon_en_o = dbg_ctrl_o[MON_BIT];

    p_strobe_excl_r1: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        $onehot0({cap_i, shift_i, upd_i}));
    p_select_r3: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        upd_i |=> (sel_q == $past(pkt.addr)));
    p_capture_r3: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        cap_i |=> (pkt.data == $past(rdata)));
endmodule

// File: tb/sim_dbg_scan_chain.sv
// Bench: two copies (vector catch on / off) driven alike; a scoreboard queue holds
// the word each scan should shift out, a monitor compares when the scan completes.
module sim_dbg_scan_chain;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic [4:0] stat = '0;
    logic tdo0, tdo1, mon0, mon1;
    logic [5:0] ctrl0, ctrl1;

    dbg_scan_chain #(.VC_EN(1'b1)) u0 (
        .tck_i(clk), .rst_n_i(rst_n), .cap_i(cap), .shift_i(sh), .upd_i(upd),
        .tdi_i(tdi), .tdo_o(tdo0), .core_status_i(stat), .dbg_ctrl_o(ctrl0), .mon_en_o(mon0));
    dbg_scan_chain #(.VC_EN(1'b0)) u1 (
        .tck_i(clk), .rst_n_i(rst_n), .cap_i(cap), .shift_i(sh), .upd_i(upd),
        .tdi_i(tdi), .tdo_o(tdo1), .core_status_i(stat), .dbg_ctrl_o(ctrl1), .mon_en_o(mon1));

    int n_chk = 0, n_fail = 0;
    logic [31:0] mdl [32];
    logic [4:0]  sel_m = '0;
    logic [31:0] q0[$], q1[$];
    string       qr[$];
    logic [31:0] act0, act1, e0, e1;
    string       rq;
    event        done;

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    function automatic logic [31:0] mread(input logic [4:0] a, input bit vc);
        if (a == 5'h01) return {27'b0, stat};
        if (a == 5'h02 && !vc) return '0;
        return mdl[a];
    endfunction

    function automatic void mwrite(input logic [4:0] a, input logic [31:0] d);
        if (a == 5'h00) mdl[a] = d & 32'h3F;
        else if (a == 5'h02 || a == 5'h04 || a == 5'h05 ||
                 (a >= 5'h08 && a <= 5'h0D) || (a >= 5'h10 && a <= 5'h15)) mdl[a] = d;
    endfunction

    // Driver: one full capture / 38-bit shift / update sequence.
    task automatic scan(input logic wr, input logic [4:0] a, input logic [31:0] d, input string req);
        logic [37:0] p;
        p = {wr, a, d};
        q0.push_back(mread(sel_m, 1'b1));
        q1.push_back(mread(sel_m, 1'b0));
        qr.push_back(req);
        @(negedge clk) cap = 1'b1;
        @(negedge clk) cap = 1'b0;
        sh = 1'b1;
        for (int i = 0; i < 38; i++) begin
            tdi = p[i];
            if (i < 32) begin
                act0[i] = tdo0;
                act1[i] = tdo1;
            end
            @(negedge clk);
        end
        sh = 1'b0;
        upd = 1'b1;
        @(negedge clk) upd = 1'b0;
        if (wr) mwrite(a, d);
        sel_m = a;
        -> done;
    endtask

    // Monitor: pop the expected words and compare with what was shifted out.
    always @(done) begin
        e0 = q0.pop_front();
        e1 = q1.pop_front();
        rq = qr.pop_front();
        chk(act0 === e0, {rq, " vc_on"}, act0, e0);
        chk(act1 === e1, {rq, " vc_off"}, act1, e1);
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports
        chk(tdo0 === 1'b0, "R9", 32'(tdo0), 0);
        chk(ctrl0 === 6'h00 && mon0 === 1'b0, "R9", 32'(ctrl0), 0);

        scan(1'b1, 5'h00, 32'hFFFF_FFFF, "R9");
        chk(ctrl0 === 6'h3F, "R2", 32'(ctrl0), 32'h3F);
        chk(mon0 === 1'b1, "R5", 32'(mon0), 1);
        scan(1'b0, 5'h00, 32'h0, "R5");               // read shows upper bits zero
        scan(1'b1, 5'h00, 32'h0000_002F, "R5");       // write back with bit 4 cleared
        chk(mon0 === 1'b0 && ctrl0 === 6'h2F, "R5", 32'(ctrl0), 32'h2F);

        for (int k = 0; k < 12; k++)                  // R4: fill both watch units
            scan(1'b1, (k < 6) ? 5'(8 + k) : 5'(10 + k), 32'hC0DE_0000 + 32'(k) * 32'h1111, "R2");
        for (int k = 0; k < 12; k++)                  // R4: pipelined reads
            scan(1'b0, (k < 6) ? 5'(8 + k) : 5'(10 + k), 32'h0, "R4");
        scan(1'b0, 5'h03, 32'h0, "R4");

        stat = 5'h15;
        scan(1'b1, 5'h01, 32'hFFFF_FFFF, "R8");       // captures unmapped 0x03
        scan(1'b0, 5'h01, 32'h0, "R6");
        stat = 5'h0A;
        scan(1'b0, 5'h02, 32'h0, "R6");

        scan(1'b1, 5'h02, 32'hA5A5_A5A5, "R7");
        scan(1'b0, 5'h02, 32'h0, "R7");
        scan(1'b1, 5'h03, 32'hDEAD_BEEF, "R7");
        scan(1'b1, 5'h1F, 32'h1234_5678, "R8");
        scan(1'b0, 5'h03, 32'h0, "R8");
        scan(1'b0, 5'h04, 32'h0, "R8");

        scan(1'b1, 5'h04, 32'h1122_3344, "R4");
        scan(1'b1, 5'h05, 32'h5566_7788, "R3");
        scan(1'b0, 5'h04, 32'h0, "R3");
        scan(1'b0, 5'h05, 32'h0, "R3");
        scan(1'b0, 5'h0D, 32'h0, "R1");
        scan(1'b0, 5'h00, 32'h0, "R1");
        scan(1'b0, 5'h00, 32'h0, "R2");               // control unchanged by reads
        chk(ctrl0 === 6'h2F, "R2", 32'(ctrl0), 32'h2F);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule